// File: doc/BRIEF.md
# Serial Ones-Residue and Even-Zeros Detector

The block watches a single serial data line and decides, after every accepted bit, whether two conditions hold together over everything received since reset: the count of ones is divisible by three, and the count of zeros is even and at least two. A bit is consumed only on a clock edge where the valid strobe is high. On every other edge the block keeps its state.

Internally, two small state machines run side by side. One keeps the ones count modulo three. The other sorts the zeros count into three classes: none yet, odd, and even-but-non-zero. The detector asserts when both machines are in their accepting states. Together they behave as one nine-state machine over the product of the two state sets.

Two forms of the result are offered. The registered (Moore) output is decoded from the stored state. The early (Mealy) output is decoded from the state that the current input would produce, so it rises in the same cycle as the completing bit. A debug bus shows the composite state.

Top module: `ones3_zeros_even_detector`

## Requirements
- R1: A synchronous active-high reset sets the ones residue to 0 and the zeros class to "none". After the reset edge, `state_dbg` reads 0 and `moore_out` reads 0.
- R2: On an edge where `valid_in` is low, the block consumes nothing. `state_dbg` and `moore_out` keep their values whatever `x_in` is.
- R3: Each consumed 1 advances the ones residue, shown in `state_dbg[3:2]`, through 0, 1, 2 and back to 0. A consumed 0 leaves the residue unchanged.
- R4: The zeros class is shown in `state_dbg[1:0]` with the codes 00 = none, 01 = odd, 10 = even and non-zero. A consumed 0 moves none to odd, odd to even, and even to odd. A consumed 1 leaves the class unchanged.
- R5: `moore_out` is 1 exactly when the stored residue is 0 and the stored zeros class is "even and non-zero". Examples of accepted (ones, zeros) counts are (0,2), (3,2), (3,4) and (6,4).
- R6: `mealy_out` is the acceptance of the state that the present input leads to. When `valid_in` is low, it therefore equals `moore_out`.
- R7: `moore_out` repeats the value that `mealy_out` had one cycle earlier. A completing bit raises `mealy_out` in its own cycle, and `moore_out` rises one cycle later.
- R8: While no zero has been received, neither output is ever 1, even when the ones count is 0 or 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| valid_in | input | 1 | High when `x_in` carries a bit to consume |
| x_in | input | 1 | Serial data bit |
| moore_out | output | 1 | Acceptance decoded from the stored state |
| mealy_out | output | 1 | Acceptance of the state the present input leads to |
| state_dbg | output | 4 | Composite state: [3:2] ones residue, [1:0] zeros class |

## Verification
The hardest situation to reach is a ones residue of zero while the zeros tracker is in a non-accepting class. One such case is three ones with no zeros at all. Another is a zeros count that has only just turned odd after an accepted pair. Both look accepting to any check that watches only one tracker. The stimulus reaches them by walking a long mixed stream through every wrap of the residue, including a return from odd to even at a count above two. Directed runs then feed ones straight after reset, and sample the early output just before the completing edge to catch the one-cycle lead over the registered output.

// File: rtl/ones3_zeros_even_pkg.sv
package ones3_zeros_even_pkg;
    typedef enum logic [1:0] {
        ZC_NONE = 2'b00,
        ZC_ODD  = 2'b01,
        ZC_EVEN = 2'b10,
        ZC_BAD  = 2'b11
    } zcls_e;
endpackage

// File: rtl/ones_residue_tracker.sv
module ones_residue_tracker #(
    parameter int MOD = 3,
    parameter int CW  = (MOD > 2) ? $clog2(MOD) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          valid,
    input  logic          din,
    output logic [CW-1:0] res_o,
    output logic          hit_now,
    output logic          hit_next
);
    localparam logic [CW-1:0] LAST = CW'(MOD - 1);

    typedef struct packed {
        logic [CW-1:0] res;
    } ost_t;

    ost_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (valid && din) begin
            if (st_q.res == LAST) st_d.res = '0;
            else                  st_d.res = st_q.res + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign res_o    = st_q.res;
    assign hit_now  = (st_q.res == '0);
    assign hit_next = (st_d.res == '0);

    // R3
    ones_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && din && st_q.res == LAST) |=> (st_q.res == '0));
    // R3
    ones_step_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && din && st_q.res != LAST) |=> (st_q.res == CW'($past(st_q.res) + 1'b1)));
    // R2
    ones_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(valid && din) |=> $stable(st_q.res));
endmodule

// File: rtl/zeros_class_tracker.sv
module zeros_class_tracker
    import ones3_zeros_even_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  valid,
    input  logic  din,
    output zcls_e cls_o,
    output logic  hit_now,
    output logic  hit_next
);
    typedef struct packed {
        zcls_e cls;
    } zst_t;

    zst_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cls == ZC_BAD) begin
            st_d.cls = ZC_NONE;
        end else if (valid && !din) begin
            case (st_q.cls)
                ZC_NONE: st_d.cls = ZC_ODD;
                ZC_ODD:  st_d.cls = ZC_EVEN;
                ZC_EVEN: st_d.cls = ZC_ODD;
                default: st_d.cls = ZC_NONE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q.cls <= ZC_NONE;
        else     st_q     <= st_d;
    end

    assign cls_o    = st_q.cls;
    assign hit_now  = (st_q.cls == ZC_EVEN);
    assign hit_next = (st_d.cls == ZC_EVEN);

    // R4
    zeros_legal_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.cls != ZC_BAD);
    // R4
    zeros_first_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && !din && st_q.cls == ZC_NONE) |=> (st_q.cls == ZC_ODD));
    // R4
    zeros_flip_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && !din && st_q.cls == ZC_EVEN) |=> (st_q.cls == ZC_ODD));
    // R4
    zeros_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(valid && !din) |=> $stable(st_q.cls));
endmodule

// File: rtl/ones3_zeros_even_detector.sv
module ones3_zeros_even_detector
    import ones3_zeros_even_pkg::*;
#(
    parameter int ONES_MOD = 3,
    localparam int OW      = (ONES_MOD > 2) ? $clog2(ONES_MOD) : 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        valid_in,
    input  logic        x_in,
    output logic        moore_out,
    output logic        mealy_out,
    output logic [OW+1:0] state_dbg
);
    logic [OW-1:0] ones_res;
    logic          ones_now, ones_next;
    zcls_e         zeros_cls;
    logic          zeros_now, zeros_next;

    ones_residue_tracker #(.MOD(ONES_MOD), .CW(OW)) u_ones (
        .clk      (clk),
        .rst      (rst),
        .valid    (valid_in),
        .din      (x_in),
        .res_o    (ones_res),
        .hit_now  (ones_now),
        .hit_next (ones_next)
    );

    zeros_class_tracker u_zeros (
        .clk      (clk),
        .rst      (rst),
        .valid    (valid_in),
        .din      (x_in),
        .cls_o    (zeros_cls),
        .hit_now  (zeros_now),
        .hit_next (zeros_next)
    );

    assign moore_out = ones_now & zeros_now;
    assign mealy_out = ones_next & zeros_next;
    assign state_dbg = {ones_res, zeros_cls};

    // R7
    moore_lag_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (moore_out == $past(mealy_out)));
    // R6
    idle_match_chk: assert property (@(posedge clk) disable iff (rst)
        !valid_in |-> (mealy_out == moore_out));
    // R5
    moore_even_chk: assert property (@(posedge clk) disable iff (rst)
        moore_out |-> (zeros_cls == ZC_EVEN && ones_res == '0));
    // R8
    none_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (zeros_cls == ZC_NONE) |-> (!mealy_out && !moore_out));
endmodule

// File: tb/ones3_zeros_even_detector_test.sv
module ones3_zeros_even_detector_test;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 5000;
    localparam int NVEC       = 15;

    // Fields: [7] valid, [6] bit, [5] mealy before edge, [4] moore after edge, [3:0] debug after edge
    localparam logic [7:0] VEC [NVEC] = '{
        8'b1000_0001, 8'b1011_0010, 8'b0111_0010, 8'b1100_0110, 8'b1100_1010,
        8'b1111_0010, 8'b1000_0001, 8'b0000_0001, 8'b1011_0010, 8'b1100_0110,
        8'b1100_1010, 8'b1111_0010, 8'b1100_0110, 8'b1000_0101, 8'b1000_0110
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic valid_in = 1'b0;
    logic x_in = 1'b0;
    logic moore_out, mealy_out;
    logic [3:0] state_dbg;
    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ones3_zeros_even_detector uut (
        .clk       (clk),
        .rst       (rst),
        .valid_in  (valid_in),
        .x_in      (x_in),
        .moore_out (moore_out),
        .mealy_out (mealy_out),
        .state_dbg (state_dbg)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; valid_in = 1'b0; x_in = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // Drive a bit at a falling edge, sample early outputs, then sample after the rising edge
    task automatic feed(input logic v, input logic b, output logic mealy_pre,
                        output logic moore_pre);
        valid_in = v; x_in = b;
        #1;
        mealy_pre = mealy_out;
        moore_pre = moore_out;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        errors++;
        $display("FAIL watchdog R1 actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic me, mo, prev_moore;
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R1: state after reset
        chk("R1 dbg", 8'(state_dbg), 8'h0);
        chk("R1 moore", 8'(moore_out), 8'h0);
        rst = 1'b0;

        // Vector table walk: R2 R3 R4 R5 R6 R7
        prev_moore = 1'b0;
        for (int i = 0; i < NVEC; i++) begin
            feed(VEC[i][7], VEC[i][6], me, mo);
            chk("R6 mealy", 8'(me), 8'(VEC[i][5]));
            chk("R7 moore before edge", 8'(mo), 8'(prev_moore));
            chk("R5 moore", 8'(moore_out), 8'(VEC[i][4]));
            chk("R3/R4 dbg", 8'(state_dbg), 8'(VEC[i][3:0]));
            prev_moore = VEC[i][4];
        end

        // R1: reset from a non-zero state
        do_reset();
        chk("R1 dbg after mid reset", 8'(state_dbg), 8'h0);
        chk("R1 moore after mid reset", 8'(moore_out), 8'h0);

        // R8: three ones without any zero
        feed(1'b1, 1'b1, me, mo);
        feed(1'b1, 1'b1, me, mo);
        chk("R3 residue two", 8'(state_dbg), 8'h8);
        feed(1'b1, 1'b1, me, mo);
        chk("R8 mealy on third one", 8'(me), 8'h0);
        chk("R8 moore after third one", 8'(moore_out), 8'h0);
        chk("R8 dbg wrapped, none", 8'(state_dbg), 8'h0);

        // R2: valid low with both bit values leaves everything
        feed(1'b0, 1'b0, me, mo);
        feed(1'b0, 1'b1, me, mo);
        chk("R2 dbg held", 8'(state_dbg), 8'h0);
        chk("R2 mealy equals moore idle", 8'(me), 8'(mo));

        // R7: completing zero raises mealy one cycle before moore
        feed(1'b1, 1'b0, me, mo);
        chk("R4 first zero odd", 8'(state_dbg), 8'h1);
        feed(1'b1, 1'b0, me, mo);
        chk("R7 mealy early", 8'(me), 8'h1);
        chk("R7 moore not yet", 8'(mo), 8'h0);
        chk("R7 moore after edge", 8'(moore_out), 8'h1);
        chk("R4 even code", 8'(state_dbg), 8'h2);

        // R2: idle with accepting state keeps moore high
        feed(1'b0, 1'b0, me, mo);
        chk("R2 moore held high", 8'(moore_out), 8'h1);
        chk("R6 idle mealy high", 8'(me), 8'h1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule